// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block holds a bank of programmable 64-bit event counters for an I/O address-translation unit. Each counter has a selector. The selector names one event code and can add filters on the requester's identity. A counter increments when an event report matches its selector. Identity is filtered either by device and process identifiers or by guest and process soft-context identifiers. The device comparison can cover an aligned range of identifiers. The range is encoded by the trailing ones of the compare value.

The owning unit drives one report per cycle at most. Software writes selectors and counter values through simple write ports. It reads back one counter at a time through an index port. A counter that wraps sets a sticky overflow-summary bit and its selector's overflow flag. Only the first wrap raises an interrupt pulse. Bit position 0 of the shared inhibit and summary vectors belongs to a cycle counter held elsewhere, so counter i sits at bit i+1.

Top module: `filt_evt_ctr_bank`

## Requirements
- R1: After reset, every counter, selector event code, selector overflow flag and summary bit reads 0, and `irq` is low.
- R2: A counter increments by one on a cycle with a valid report only if its event code is nonzero, its event code equals the reported code, and its inhibit bit (bit i+1 of `inhibit`) is 0.
- R3: A selector write whose event code is 0 or is not below NUM_EVT_IDS stores event code 0. Codes 1 to NUM_EVT_IDS-1 are stored as written. A report with code 0 never increments a counter.
- R4: With the identifier-type bit set, filtering compares against the guest soft-context ID and the process soft-context ID. With it clear, filtering uses the device ID and the process ID.
- R5: With process matching enabled, a report with a nonzero process ID counts only when the selected process identifier equals the selector's process value. A report with process ID 0 passes this filter.
- R6: With device matching enabled, the selector's device value v and the selected device identifier must agree under a mask. The mask is all ones when mask mode is off, and ~(v ^ (v+1)) when it is on. For example, v=0x9B accepts 0x98..0x9F only.
- R7: An increment from all ones wraps the counter to 0. If summary bit i+1 was clear, that bit and the selector's overflow flag become 1, and `irq` is high for exactly the cycle after the wrap. A wrap with the bit already set gives no pulse.
- R8: A selector write with its overflow flag 0 clears summary bit i+1. A write with the flag 1 leaves it unchanged.
- R9: Selector and counter writes to an index at or above NUM_CTRS change nothing. While `hpmEnable` is low, writes and reports change nothing and `irq` stays low.
- R10: A counter write or selector write to counter i in the same cycle as a matching report wins. The report does not increment that counter.
- R11: Wraps of several counters in one cycle produce a single one-cycle `irq` pulse and set all their summary bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpmEnable | input | 1 | Performance-monitor capability present; low makes the bank inert |
| inhibit | input | NUM_CTRS (bits NUM_CTRS:1) | Per-counter count inhibit, counter i at bit i+1 |
| selWrEn | input | 1 | Selector write strobe |
| selWrIdx | input | IDX_W | Selector write counter index |
| selWrEvtId | input | EVT_W | Event code to write |
| selWrIdType | input | 1 | 1: soft-context IDs, 0: device/process IDs |
| selWrProcEn | input | 1 | Process-identifier match enable |
| selWrDevEn | input | 1 | Device-identifier match enable |
| selWrMaskEn | input | 1 | Range-mask mode for the device compare |
| selWrDevVal | input | DEV_W | Device/guest-context compare value |
| selWrProcVal | input | PROC_W | Process/process-context compare value |
| selWrOvf | input | 1 | Overflow flag value to write |
| ctrWrEn | input | 1 | Counter write strobe |
| ctrWrIdx | input | IDX_W | Counter write index |
| ctrWrData | input | 64 | Counter write value |
| repValid | input | 1 | Event report valid this cycle |
| repEvtId | input | EVT_W | Reported event code |
| repDevId | input | DEV_W | Reported device ID |
| repProcId | input | PROC_W | Reported process ID (0: none) |
| repGscId | input | DEV_W | Reported guest soft-context ID |
| repPscId | input | PROC_W | Reported process soft-context ID |
| rdIdx | input | IDX_W | Readback counter index |
| rdCount | output | 64 | Counter value at rdIdx (0 if unimplemented) |
| rdEvtId | output | EVT_W | Stored event code at rdIdx |
| rdOvfFlag | output | 1 | Selector overflow flag at rdIdx |
| ovfSummary | output | NUM_CTRS (bits NUM_CTRS:1) | Sticky overflow summary, counter i at bit i+1 |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
All state is a single register stage behind the inputs. A write or report applied before a clock edge shows in `rdCount`, `rdEvtId`, `rdOvfFlag` and `ovfSummary` right after that edge. `irq` is high for the one cycle after the edge that caused a first wrap. The bench drives inputs on falling edges. It reads the combinational readback on the next falling edge, one rising edge later. It samples `irq` both at that falling edge and one cycle later, to confirm the pulse is one cycle wide.

// File: rtl/fecb_pkg.sv
`timescale 1ns/1ps
package fecb_pkg;
  // Per-counter strobes from control to datapath
  typedef struct packed {
    logic selWr;   // selector write this cycle
    logic ctrWr;   // counter value write this cycle
    logic inc;     // filtered increment this cycle
  } ctrStrobe_t;
endpackage

// File: rtl/fecb_filter.sv
`timescale 1ns/1ps
module fecb_filter #(
  parameter int EVT_W  = 8,
  parameter int DEV_W  = 24,
  parameter int PROC_W = 20
) (
  input  logic [EVT_W-1:0]  evtId,
  input  logic              idType,
  input  logic              procEn,
  input  logic              devEn,
  input  logic              maskEn,
  input  logic [DEV_W-1:0]  devVal,
  input  logic [PROC_W-1:0] procVal,
  input  logic              repValid,
  input  logic [EVT_W-1:0]  repEvtId,
  input  logic [DEV_W-1:0]  repDevId,
  input  logic [PROC_W-1:0] repProcId,
  input  logic [DEV_W-1:0]  repGscId,
  input  logic [PROC_W-1:0] repPscId,
  output logic              hit
);
  logic [DEV_W-1:0]  devSel, devMask;
  logic [PROC_W-1:0] procSel;
  logic              evtOk, procOk, devOk;

  always_comb begin
    devSel  = idType ? repGscId : repDevId;
    procSel = idType ? repPscId : repProcId;
    // trailing ones of devVal plus the zero above them are don't-care
    devMask = maskEn ? ~(devVal ^ (devVal + DEV_W'(1))) : '1;
    evtOk   = (evtId != '0) && (evtId == repEvtId);
    procOk  = !procEn || (repProcId == '0) || (procSel == procVal);
    devOk   = !devEn || ((devSel & devMask) == (devVal & devMask));
    hit     = repValid && evtOk && procOk && devOk;
  end
endmodule

// File: rtl/fecb_ctrl.sv
`timescale 1ns/1ps
module fecb_ctrl
  import fecb_pkg::*;
#(
  parameter int NUM_CTRS    = 8,
  parameter int NUM_EVT_IDS = 9,
  parameter int EVT_W       = 8,
  parameter int DEV_W       = 24,
  parameter int PROC_W      = 20,
  localparam int IDX_W      = $clog2(NUM_CTRS) + 1
) (
  input  logic              hpmEnable,
  input  logic [NUM_CTRS:1] inhibit,
  input  logic              selWrEn,
  input  logic [IDX_W-1:0]  selWrIdx,
  input  logic [EVT_W-1:0]  selWrEvtId,
  input  logic              ctrWrEn,
  input  logic [IDX_W-1:0]  ctrWrIdx,
  input  logic              repValid,
  input  logic [EVT_W-1:0]  repEvtId,
  input  logic [DEV_W-1:0]  repDevId,
  input  logic [PROC_W-1:0] repProcId,
  input  logic [DEV_W-1:0]  repGscId,
  input  logic [PROC_W-1:0] repPscId,
  input  logic [EVT_W-1:0]  evtId   [NUM_CTRS],
  input  logic              idType  [NUM_CTRS],
  input  logic              procEn  [NUM_CTRS],
  input  logic              devEn   [NUM_CTRS],
  input  logic              maskEn  [NUM_CTRS],
  input  logic [DEV_W-1:0]  devVal  [NUM_CTRS],
  input  logic [PROC_W-1:0] procVal [NUM_CTRS],
  output logic [EVT_W-1:0]  evtWrVal,
  output ctrStrobe_t        strb    [NUM_CTRS]
);
  // unsupported codes collapse to the invalid code 0
  always_comb begin
    if ((selWrEvtId != '0) && ({1'b0, selWrEvtId} < (EVT_W+1)'(NUM_EVT_IDS)))
      evtWrVal = selWrEvtId;
    else
      evtWrVal = '0;
  end

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    logic hit;
    fecb_filter #(.EVT_W(EVT_W), .DEV_W(DEV_W), .PROC_W(PROC_W)) u_filt (
      .evtId(evtId[i]), .idType(idType[i]), .procEn(procEn[i]),
      .devEn(devEn[i]), .maskEn(maskEn[i]), .devVal(devVal[i]),
      .procVal(procVal[i]), .repValid(repValid), .repEvtId(repEvtId),
      .repDevId(repDevId), .repProcId(repProcId), .repGscId(repGscId),
      .repPscId(repPscId), .hit(hit)
    );
    always_comb begin
      strb[i].selWr = hpmEnable && selWrEn && (selWrIdx == IDX_W'(i));
      strb[i].ctrWr = hpmEnable && ctrWrEn && (ctrWrIdx == IDX_W'(i));
      strb[i].inc   = hpmEnable && hit && !inhibit[i+1]
                      && !strb[i].selWr && !strb[i].ctrWr;
    end
  end
endmodule

// File: rtl/fecb_dpath.sv
`timescale 1ns/1ps
module fecb_dpath
  import fecb_pkg::*;
#(
  parameter int NUM_CTRS = 8,
  parameter int EVT_W    = 8,
  parameter int DEV_W    = 24,
  parameter int PROC_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrStrobe_t        strb    [NUM_CTRS],
  input  logic [EVT_W-1:0]  evtWrVal,
  input  logic              selWrIdType,
  input  logic              selWrProcEn,
  input  logic              selWrDevEn,
  input  logic              selWrMaskEn,
  input  logic [DEV_W-1:0]  selWrDevVal,
  input  logic [PROC_W-1:0] selWrProcVal,
  input  logic              selWrOvf,
  input  logic [63:0]       ctrWrData,
  output logic [63:0]       count   [NUM_CTRS],
  output logic [EVT_W-1:0]  evtId   [NUM_CTRS],
  output logic              idType  [NUM_CTRS],
  output logic              procEn  [NUM_CTRS],
  output logic              devEn   [NUM_CTRS],
  output logic              maskEn  [NUM_CTRS],
  output logic [DEV_W-1:0]  devVal  [NUM_CTRS],
  output logic [PROC_W-1:0] procVal [NUM_CTRS],
  output logic              ovfFlag [NUM_CTRS],
  output logic [NUM_CTRS:1] sumBits,
  output logic              irq
);
  logic [NUM_CTRS-1:0] freshOvf;

  always_comb begin
    for (int i = 0; i < NUM_CTRS; i++)
      freshOvf[i] = strb[i].inc && (count[i] == '1) && !sumBits[i+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTRS; i++) begin
        count[i]   <= '0;
        evtId[i]   <= '0;
        idType[i]  <= 1'b0;
        procEn[i]  <= 1'b0;
        devEn[i]   <= 1'b0;
        maskEn[i]  <= 1'b0;
        devVal[i]  <= '0;
        procVal[i] <= '0;
        ovfFlag[i] <= 1'b0;
      end
      sumBits <= '0;
      irq     <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CTRS; i++) begin
        if (strb[i].ctrWr)    count[i] <= ctrWrData;
        else if (strb[i].inc) count[i] <= count[i] + 64'd1;

        if (strb[i].selWr) begin
          evtId[i]   <= evtWrVal;
          idType[i]  <= selWrIdType;
          procEn[i]  <= selWrProcEn;
          devEn[i]   <= selWrDevEn;
          maskEn[i]  <= selWrMaskEn;
          devVal[i]  <= selWrDevVal;
          procVal[i] <= selWrProcVal;
          ovfFlag[i] <= selWrOvf;
          if (!selWrOvf) sumBits[i+1] <= 1'b0;
        end else if (freshOvf[i]) begin
          ovfFlag[i]   <= 1'b1;
          sumBits[i+1] <= 1'b1;
        end
      end
      irq <= |freshOvf;
    end
  end
endmodule

// File: rtl/filt_evt_ctr_bank.sv
`timescale 1ns/1ps
module filt_evt_ctr_bank
  import fecb_pkg::*;
#(
  parameter int NUM_CTRS    = 8,
  parameter int NUM_EVT_IDS = 9,
  parameter int EVT_W       = 8,
  parameter int DEV_W       = 24,
  parameter int PROC_W      = 20,
  localparam int IDX_W      = $clog2(NUM_CTRS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpmEnable,
  input  logic [NUM_CTRS:1] inhibit,
  input  logic              selWrEn,
  input  logic [IDX_W-1:0]  selWrIdx,
  input  logic [EVT_W-1:0]  selWrEvtId,
  input  logic              selWrIdType,
  input  logic              selWrProcEn,
  input  logic              selWrDevEn,
  input  logic              selWrMaskEn,
  input  logic [DEV_W-1:0]  selWrDevVal,
  input  logic [PROC_W-1:0] selWrProcVal,
  input  logic              selWrOvf,
  input  logic              ctrWrEn,
  input  logic [IDX_W-1:0]  ctrWrIdx,
  input  logic [63:0]       ctrWrData,
  input  logic              repValid,
  input  logic [EVT_W-1:0]  repEvtId,
  input  logic [DEV_W-1:0]  repDevId,
  input  logic [PROC_W-1:0] repProcId,
  input  logic [DEV_W-1:0]  repGscId,
  input  logic [PROC_W-1:0] repPscId,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [63:0]       rdCount,
  output logic [EVT_W-1:0]  rdEvtId,
  output logic              rdOvfFlag,
  output logic [NUM_CTRS:1] ovfSummary,
  output logic              irq
);
  ctrStrobe_t        strb    [NUM_CTRS];
  logic [EVT_W-1:0]  evtWrVal;
  logic [63:0]       count   [NUM_CTRS];
  logic [EVT_W-1:0]  evtId   [NUM_CTRS];
  logic              idType  [NUM_CTRS];
  logic              procEn  [NUM_CTRS];
  logic              devEn   [NUM_CTRS];
  logic              maskEn  [NUM_CTRS];
  logic [DEV_W-1:0]  devVal  [NUM_CTRS];
  logic [PROC_W-1:0] procVal [NUM_CTRS];
  logic              ovfFlag [NUM_CTRS];

  fecb_ctrl #(.NUM_CTRS(NUM_CTRS), .NUM_EVT_IDS(NUM_EVT_IDS), .EVT_W(EVT_W),
              .DEV_W(DEV_W), .PROC_W(PROC_W)) u_ctrl (
    .hpmEnable(hpmEnable), .inhibit(inhibit), .selWrEn(selWrEn),
    .selWrIdx(selWrIdx), .selWrEvtId(selWrEvtId), .ctrWrEn(ctrWrEn),
    .ctrWrIdx(ctrWrIdx), .repValid(repValid), .repEvtId(repEvtId),
    .repDevId(repDevId), .repProcId(repProcId), .repGscId(repGscId),
    .repPscId(repPscId), .evtId(evtId), .idType(idType), .procEn(procEn),
    .devEn(devEn), .maskEn(maskEn), .devVal(devVal), .procVal(procVal),
    .evtWrVal(evtWrVal), .strb(strb)
  );

  fecb_dpath #(.NUM_CTRS(NUM_CTRS), .EVT_W(EVT_W), .DEV_W(DEV_W),
               .PROC_W(PROC_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .evtWrVal(evtWrVal),
    .selWrIdType(selWrIdType), .selWrProcEn(selWrProcEn),
    .selWrDevEn(selWrDevEn), .selWrMaskEn(selWrMaskEn),
    .selWrDevVal(selWrDevVal), .selWrProcVal(selWrProcVal),
    .selWrOvf(selWrOvf), .ctrWrData(ctrWrData), .count(count),
    .evtId(evtId), .idType(idType), .procEn(procEn), .devEn(devEn),
    .maskEn(maskEn), .devVal(devVal), .procVal(procVal),
    .ovfFlag(ovfFlag), .sumBits(ovfSummary), .irq(irq)
  );

  always_comb begin
    rdCount   = '0;
    rdEvtId   = '0;
    rdOvfFlag = 1'b0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (rdIdx == IDX_W'(i)) begin
        rdCount   = count[i];
        rdEvtId   = evtId[i];
        rdOvfFlag = ovfFlag[i];
      end
    end
  end
endmodule

// File: rtl/fecb_checker.sv
`timescale 1ns/1ps
module fecb_checker #(
  parameter int NUM_CTRS = 8,
  localparam int IDX_W   = $clog2(NUM_CTRS) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hpmEnable,
  input logic [NUM_CTRS:1] inhibit,
  input logic              selWrEn,
  input logic [IDX_W-1:0]  selWrIdx,
  input logic              selWrOvf,
  input logic [NUM_CTRS:1] ovfSummary,
  input logic              irq
);
  // R7
  irq_needs_new_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(ovfSummary) > $countones($past(ovfSummary))));

  // R9
  inert_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hpmEnable |=> !irq);

  // R9
  inert_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hpmEnable |=> $stable(ovfSummary));

  // R2
  all_inhibited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit == '1) |=> !irq);

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_clr
    // R8
    summary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hpmEnable && selWrEn && selWrIdx == IDX_W'(i) && !selWrOvf)
        |=> !ovfSummary[i+1]);
  end
endmodule

bind filt_evt_ctr_bank fecb_checker #(.NUM_CTRS(NUM_CTRS)) u_fecb_checker (
  .clk(clk), .rst_n(rst_n), .hpmEnable(hpmEnable), .inhibit(inhibit),
  .selWrEn(selWrEn), .selWrIdx(selWrIdx), .selWrOvf(selWrOvf),
  .ovfSummary(ovfSummary), .irq(irq)
);

// File: tb/test_filt_evt_ctr_bank.sv
`timescale 1ns/1ps
module test_filt_evt_ctr_bank;
  localparam int N = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hpmEnable = 1'b1;
  logic [N:1] inhibit = '0;
  logic selWrEn = 0, selWrIdType = 0, selWrProcEn = 0, selWrDevEn = 0;
  logic selWrMaskEn = 0, selWrOvf = 0;
  logic [IW-1:0] selWrIdx = '0, ctrWrIdx = '0, rdIdx = '0;
  logic [7:0] selWrEvtId = '0, repEvtId = '0;
  logic [23:0] selWrDevVal = '0, repDevId = '0, repGscId = '0;
  logic [19:0] selWrProcVal = '0, repProcId = '0, repPscId = '0;
  logic ctrWrEn = 0, repValid = 0;
  logic [63:0] ctrWrData = '0;
  logic [63:0] rdCount;
  logic [7:0] rdEvtId;
  logic rdOvfFlag, irq;
  logic [N:1] ovfSummary;

  int tests = 0, fails = 0;
  logic irqAfter;

  always #5 clk = ~clk;

  filt_evt_ctr_bank i_filt_evt_ctr_bank (
    .clk(clk), .rst_n(rst_n), .hpmEnable(hpmEnable), .inhibit(inhibit),
    .selWrEn(selWrEn), .selWrIdx(selWrIdx), .selWrEvtId(selWrEvtId),
    .selWrIdType(selWrIdType), .selWrProcEn(selWrProcEn),
    .selWrDevEn(selWrDevEn), .selWrMaskEn(selWrMaskEn),
    .selWrDevVal(selWrDevVal), .selWrProcVal(selWrProcVal),
    .selWrOvf(selWrOvf), .ctrWrEn(ctrWrEn), .ctrWrIdx(ctrWrIdx),
    .ctrWrData(ctrWrData), .repValid(repValid), .repEvtId(repEvtId),
    .repDevId(repDevId), .repProcId(repProcId), .repGscId(repGscId),
    .repPscId(repPscId), .rdIdx(rdIdx), .rdCount(rdCount),
    .rdEvtId(rdEvtId), .rdOvfFlag(rdOvfFlag), .ovfSummary(ovfSummary),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setSel(input int idx, input int evt, input bit idt, input bit pe,
                        input bit de, input bit me, input logic [23:0] dv,
                        input logic [19:0] pv, input bit of);
    selWrIdx = IW'(idx); selWrEvtId = 8'(evt); selWrIdType = idt;
    selWrProcEn = pe; selWrDevEn = de; selWrMaskEn = me;
    selWrDevVal = dv; selWrProcVal = pv; selWrOvf = of; selWrEn = 1'b1;
  endtask

  task automatic selWr(input int idx, input int evt, input bit idt, input bit pe,
                       input bit de, input bit me, input logic [23:0] dv,
                       input logic [19:0] pv, input bit of);
    @(negedge clk);
    setSel(idx, evt, idt, pe, de, me, dv, pv, of);
    @(negedge clk);
    selWrEn = 1'b0;
  endtask

  task automatic ctrWr(input int idx, input logic [63:0] val);
    @(negedge clk);
    ctrWrIdx = IW'(idx); ctrWrData = val; ctrWrEn = 1'b1;
    @(negedge clk);
    ctrWrEn = 1'b0;
  endtask

  task automatic setRep(input int evt, input logic [23:0] dev, input logic [19:0] pid,
                        input logic [23:0] gsc, input logic [19:0] psc);
    repEvtId = 8'(evt); repDevId = dev; repProcId = pid;
    repGscId = gsc; repPscId = psc; repValid = 1'b1;
  endtask

  task automatic rep(input int evt, input logic [23:0] dev, input logic [19:0] pid,
                     input logic [23:0] gsc, input logic [19:0] psc);
    @(negedge clk);
    setRep(evt, dev, pid, gsc, psc);
    @(negedge clk);
    irqAfter = irq;
    repValid = 1'b0;
  endtask

  function automatic logic [63:0] cnt(input int idx);
    rdIdx = IW'(idx);
    return 64'(0);
  endfunction

  task automatic rdCnt(input int idx, output logic [63:0] c, output logic [7:0] e,
                       output logic f);
    rdIdx = IW'(idx);
    #1;
    c = rdCount; e = rdEvtId; f = rdOvfFlag;
  endtask

  task automatic t_reset();
    logic [63:0] c; logic [7:0] e; logic f;
    for (int i = 0; i < N; i++) begin
      rdCnt(i, c, e, f);
      chk("R1 count", c, 0);
      chk("R1 evt", 64'(e), 0);
      chk("R1 flag", 64'(f), 0);
    end
    chk("R1 summary", 64'(ovfSummary), 0);
    chk("R1 irq", 64'(irq), 0);
  endtask

  task automatic t_basic();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(0, 3, 0, 0, 0, 0, 0, 0, 0);
    rep(3, 1, 1, 1, 1); rep(3, 2, 0, 2, 2); rep(3, 9, 4, 9, 4);
    rep(4, 1, 1, 1, 1);
    rdCnt(0, c, e, f);
    chk("R2 match count", c, 3);
    inhibit[1] = 1'b1;
    rep(3, 1, 1, 1, 1);
    rdCnt(0, c, e, f);
    chk("R2 inhibited", c, 3);
    inhibit = '0;
  endtask

  task automatic t_warl();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(1, 200, 0, 0, 0, 0, 0, 0, 0);
    rdCnt(1, c, e, f);
    chk("R3 coerce 200", 64'(e), 0);
    rep(0, 0, 0, 0, 0);
    rdCnt(1, c, e, f);
    chk("R3 code0 no count", c, 0);
    selWr(1, 9, 0, 0, 0, 0, 0, 0, 0);
    rdCnt(1, c, e, f);
    chk("R3 coerce limit", 64'(e), 0);
    selWr(1, 8, 0, 0, 0, 0, 0, 0, 0);
    rdCnt(1, c, e, f);
    chk("R3 top valid code", 64'(e), 8);
  endtask

  task automatic t_idtype();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(2, 5, 1, 0, 1, 0, 24'h77, 0, 0);
    rep(5, 24'h77, 0, 24'h10, 0);
    rep(5, 24'h10, 0, 24'h77, 0);
    rdCnt(2, c, e, f);
    chk("R4 soft-context select", c, 1);
    selWr(2, 5, 0, 0, 1, 0, 24'h77, 0, 0);
    rep(5, 24'h77, 0, 24'h10, 0);
    rdCnt(2, c, e, f);
    chk("R4 device select", c, 2);
  endtask

  task automatic t_pid();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(3, 6, 0, 1, 0, 0, 0, 20'h55, 0);
    rep(6, 0, 20'h55, 0, 0);
    rep(6, 0, 20'h0, 0, 0);
    rep(6, 0, 20'h54, 0, 0);
    rdCnt(3, c, e, f);
    chk("R5 process filter/wildcard", c, 2);
  endtask

  task automatic t_mask();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(4, 7, 0, 0, 1, 1, 24'h9B, 0, 0);
    rep(7, 24'h98, 0, 0, 0); rep(7, 24'h9F, 0, 0, 0);
    rep(7, 24'h97, 0, 0, 0); rep(7, 24'hA0, 0, 0, 0);
    rdCnt(4, c, e, f);
    chk("R6 range mask", c, 2);
    selWr(4, 7, 0, 0, 1, 0, 24'h9B, 0, 0);
    rep(7, 24'h98, 0, 0, 0); rep(7, 24'h9B, 0, 0, 0);
    rdCnt(4, c, e, f);
    chk("R6 exact compare", c, 3);
  endtask

  task automatic t_ovf();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(5, 2, 0, 0, 0, 0, 0, 0, 0);
    ctrWr(5, '1);
    rep(2, 0, 0, 0, 0);
    chk("R7 irq pulse", 64'(irqAfter), 1);
    rdCnt(5, c, e, f);
    chk("R7 wrap", c, 0);
    chk("R7 flag", 64'(f), 1);
    chk("R7 summary", 64'(ovfSummary[6]), 1);
    @(negedge clk);
    chk("R7 pulse width", 64'(irq), 0);
    ctrWr(5, '1);
    rep(2, 0, 0, 0, 0);
    chk("R7 no second irq", 64'(irqAfter), 0);
    selWr(5, 2, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 flag1 keeps summary", 64'(ovfSummary[6]), 1);
    selWr(5, 2, 0, 0, 0, 0, 0, 0, 0);
    rdCnt(5, c, e, f);
    chk("R8 summary cleared", 64'(ovfSummary[6]), 0);
    chk("R8 flag cleared", 64'(f), 0);
  endtask

  task automatic t_merge();
    selWr(6, 4, 0, 0, 0, 0, 0, 0, 0);
    selWr(7, 4, 0, 0, 0, 0, 0, 0, 0);
    ctrWr(6, '1); ctrWr(7, '1);
    rep(4, 0, 0, 0, 0);
    chk("R11 merged irq", 64'(irqAfter), 1);
    chk("R11 both summaries", 64'(ovfSummary[8:7]), 3);
    @(negedge clk);
    chk("R11 single pulse", 64'(irq), 0);
  endtask

  task automatic t_ignore();
    logic [63:0] c; logic [7:0] e; logic f;
    selWr(8, 1, 0, 0, 0, 0, 0, 0, 0);
    ctrWr(8, 64'd77);
    rdCnt(0, c, e, f);
    chk("R9 bad index selector", 64'(e), 3);
    chk("R9 bad index counter", c, 3);
    hpmEnable = 1'b0;
    selWr(0, 1, 0, 0, 0, 0, 0, 0, 0);
    rep(3, 0, 0, 0, 0);
    rdCnt(0, c, e, f);
    chk("R9 inert selector", 64'(e), 3);
    chk("R9 inert count", c, 3);
    hpmEnable = 1'b1;
  endtask

  task automatic t_wrwins();
    logic [63:0] c; logic [7:0] e; logic f;
    @(negedge clk);
    ctrWrIdx = IW'(0); ctrWrData = 64'd100; ctrWrEn = 1'b1;
    setRep(3, 0, 0, 0, 0);
    @(negedge clk);
    ctrWrEn = 1'b0; repValid = 1'b0;
    rdCnt(0, c, e, f);
    chk("R10 counter write wins", c, 100);
    @(negedge clk);
    setSel(0, 3, 0, 0, 0, 0, 0, 0, 0);
    setRep(3, 0, 0, 0, 0);
    @(negedge clk);
    selWrEn = 1'b0; repValid = 1'b0;
    rdCnt(0, c, e, f);
    chk("R10 selector write blocks inc", c, 100);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    irqAfter = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_warl();
    t_idtype();
    t_pid();
    t_mask();
    t_ovf();
    t_merge();
    t_ignore();
    t_wrwins();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule